// File: doc/BRIEF.md
# RGB to HMMD Color Converter

This block turns a stream of 24-bit RGB pixels, eight bits per channel, into the five attributes of the hue-max-min-diff colour space. These are the largest channel, the smallest channel, their difference, their truncated mean and a hue angle in whole degrees. It accepts one pixel on every clock cycle. Each result leaves exactly 29 cycles after its pixel entered, together with a valid flag that mirrors the input flag.

Inside, a front section finds the extreme channels and picks a hue sector. It takes the magnitude of the relevant channel difference and scales it by sixty. A chain of restoring-division steps then divides that product by Diff, producing one quotient bit per stage. A final stage adds or subtracts the quotient from the sector's base angle and handles the gray case. A balancing delay pads the pipeline to the fixed latency. A downstream quantizer or histogram unit consumes the outputs as a plain valid-qualified stream.

Top module: `rgb2hmmd`

## Requirements
- R1: `out_max` equals the largest and `out_min` the smallest of the three channels of the pixel that produced the result.
- R2: `out_diff` equals `out_max` minus `out_min`.
- R3: `out_sum` equals `out_max` plus `out_min` shifted right by one bit, with the low bit dropped.
- R4: When all three channels are equal (Diff is zero), `out_hue` is 0.
- R5: When red is the maximum and green is at least blue, `out_hue` is 60*(G-B)/Diff, truncated.
- R6: When red is the maximum and green is below blue, `out_hue` is 360 minus the truncated value of 60*(B-G)/Diff, and a result of 360 becomes 0.
- R7: When green is the maximum and red is not, `out_hue` is 120 plus 60*(B-R)/Diff, with the quotient truncated toward zero for either sign.
- R8: When blue alone is the maximum, `out_hue` is 240 plus 60*(R-G)/Diff, with the quotient truncated toward zero for either sign.
- R9: On ties for the maximum, red wins over green and blue, and green wins over blue.
- R10: `out_hue` is always an integer from 0 to 359.
- R11: A new pixel may enter on every cycle. `out_valid` equals `in_valid` delayed by exactly 29 cycles, and results leave in arrival order.
- R12: A synchronous reset drops `out_valid` to 0 on the next clock edge. Pixels in flight at reset never appear at the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Pixel present on the input this cycle |
| in_r | input | 8 | Red channel |
| in_g | input | 8 | Green channel |
| in_b | input | 8 | Blue channel |
| out_valid | output | 1 | Result present on the outputs this cycle |
| out_max | output | 8 | Largest channel |
| out_min | output | 8 | Smallest channel |
| out_diff | output | 8 | Max minus Min |
| out_sum | output | 8 | (Max + Min) / 2, truncated |
| out_hue | output | 9 | Hue angle in degrees, 0 to 359 |

## Verification
Because the datapath is full-throughput, the divider's zero-divisor path for a gray pixel can run in the same cycle as ordinary chromatic divisions in the neighbouring stages. A pixel can also enter in the very cycle that an older result leaves. The stream test provokes both. It sends back-to-back pixels that interleave gray, tied and chromatic values, with occasional idle gaps. Each output is judged against a bench-side model, both for its value and for the exact cycle it appears in. A mid-stream reset then shows that pixels still inside the divider are dropped rather than leaking out.

// File: rtl/hmmd_pkg.sv
`timescale 1ns/1ps
package hmmd_pkg;

    localparam int PIX_W  = 8;            // bits per colour channel
    localparam int QW     = 6;            // quotient bits, result never exceeds 60
    localparam int NUM_W  = PIX_W + QW;   // width of 60 * channel difference
    localparam int HUE_W  = 9;            // hue degrees 0..359

    localparam logic [NUM_W-1:0] SCALE    = NUM_W'(60);
    localparam logic [HUE_W-1:0] HUE_FULL = HUE_W'(360);

    typedef enum logic [1:0] {
        SEC_GRAY  = 2'd0,
        SEC_RED   = 2'd1,
        SEC_GREEN = 2'd2,
        SEC_BLUE  = 2'd3
    } sector_e;

    // attributes that ride alongside the divider
    typedef struct packed {
        logic [PIX_W-1:0] mx;
        logic [PIX_W-1:0] mn;
        logic [PIX_W-1:0] df;
        logic [PIX_W-1:0] sm;
        sector_e          sec;
        logic             neg;
    } attr_t;

    // working state of the restoring divider
    typedef struct packed {
        logic [NUM_W-1:0] rem;
        logic [PIX_W-1:0] dvs;
        logic [QW-1:0]    quot;
    } div_t;

    // finished result
    typedef struct packed {
        logic [PIX_W-1:0] mx;
        logic [PIX_W-1:0] mn;
        logic [PIX_W-1:0] df;
        logic [PIX_W-1:0] sm;
        logic [HUE_W-1:0] hue;
    } out_t;

    function automatic logic [PIX_W-1:0] max3(input logic [PIX_W-1:0] a,
                                              input logic [PIX_W-1:0] b,
                                              input logic [PIX_W-1:0] c);
        logic [PIX_W-1:0] t;
        t = (a >= b) ? a : b;
        return (t >= c) ? t : c;
    endfunction

    function automatic logic [PIX_W-1:0] min3(input logic [PIX_W-1:0] a,
                                              input logic [PIX_W-1:0] b,
                                              input logic [PIX_W-1:0] c);
        logic [PIX_W-1:0] t;
        t = (a <= b) ? a : b;
        return (t <= c) ? t : c;
    endfunction

    // base angle of a sector; the red sector wraps from 360 when the
    // difference is negative
    function automatic logic [HUE_W-1:0] hue_base(input sector_e s, input logic neg);
        logic [HUE_W-1:0] b;
        case (s)
            SEC_RED:   b = neg ? HUE_FULL : '0;
            SEC_GREEN: b = HUE_W'(120);
            SEC_BLUE:  b = HUE_W'(240);
            default:   b = '0;
        endcase
        return b;
    endfunction

endpackage

// File: rtl/hmmd_front.sv
`timescale 1ns/1ps
module hmmd_front
    import hmmd_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [PIX_W-1:0] in_r,
    input  logic [PIX_W-1:0] in_g,
    input  logic [PIX_W-1:0] in_b,
    output logic             v_o,
    output attr_t            attr_o,
    output div_t             div_o
);

    // stage 1: capture pixel
    logic             v1;
    logic [PIX_W-1:0] r1, g1, b1;

    always_ff @(posedge clk) begin
        if (rst) v1 <= 1'b0;
        else     v1 <= in_valid;
        r1 <= in_r;
        g1 <= in_g;
        b1 <= in_b;
    end

    // stage 2: extremes, sector choice, signed difference
    logic [PIX_W-1:0] mx_c, mn_c, pa_c, pb_c, mag_c;
    sector_e          sec_c;
    logic             neg_c;

    always_comb begin
        mx_c = max3(r1, g1, b1);
        mn_c = min3(r1, g1, b1);
        if (mx_c == mn_c)    sec_c = SEC_GRAY;
        else if (r1 == mx_c) sec_c = SEC_RED;
        else if (g1 == mx_c) sec_c = SEC_GREEN;
        else                 sec_c = SEC_BLUE;
        case (sec_c)
            SEC_GREEN: begin pa_c = b1; pb_c = r1; end
            SEC_BLUE:  begin pa_c = r1; pb_c = g1; end
            default:   begin pa_c = g1; pb_c = b1; end
        endcase
        neg_c = (pa_c < pb_c);
        mag_c = neg_c ? (pb_c - pa_c) : (pa_c - pb_c);
    end

    logic             v2;
    logic [PIX_W-1:0] mx2, mn2, mag2;
    sector_e          sec2;
    logic             neg2;

    always_ff @(posedge clk) begin
        if (rst) v2 <= 1'b0;
        else     v2 <= v1;
        mx2  <= mx_c;
        mn2  <= mn_c;
        mag2 <= mag_c;
        sec2 <= sec_c;
        neg2 <= neg_c;
    end

    // stage 3: diff, sum, scale by sixty
    logic [PIX_W:0]   wide_sum;
    logic [PIX_W-1:0] df_c;
    assign wide_sum = {1'b0, mx2} + {1'b0, mn2};
    assign df_c     = mx2 - mn2;

    always_ff @(posedge clk) begin
        if (rst) v_o <= 1'b0;
        else     v_o <= v2;
        attr_o.mx  <= mx2;
        attr_o.mn  <= mn2;
        attr_o.df  <= df_c;
        attr_o.sm  <= wide_sum[PIX_W:1];
        attr_o.sec <= sec2;
        attr_o.neg <= neg2;
        div_o.rem  <= NUM_W'(mag2) * SCALE;
        div_o.dvs  <= df_c;
        div_o.quot <= '0;
    end

endmodule

// File: rtl/hmmd_div_step.sv
`timescale 1ns/1ps
module hmmd_div_step
    import hmmd_pkg::*;
#(
    parameter int BIT = 0
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  v_i,
    input  attr_t attr_i,
    input  div_t  div_i,
    output logic  v_o,
    output attr_t attr_o,
    output div_t  div_o
);

    localparam int WIDE = NUM_W + QW;

    logic [WIDE-1:0] num_w, sh_w;
    div_t            nxt;

    always_comb begin
        num_w = WIDE'(div_i.rem);
        sh_w  = WIDE'(div_i.dvs) << BIT;
        nxt   = div_i;
        if (num_w >= sh_w) begin
            nxt.rem       = NUM_W'(num_w - sh_w);
            nxt.quot[BIT] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) v_o <= 1'b0;
        else     v_o <= v_i;
        attr_o <= attr_i;
        div_o  <= nxt;
    end

endmodule

// File: rtl/hmmd_hue_out.sv
`timescale 1ns/1ps
module hmmd_hue_out
    import hmmd_pkg::*;
#(
    parameter int PAD = 19
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          v_i,
    input  attr_t         attr_i,
    input  logic [QW-1:0] quot_i,
    output logic          v_o,
    output out_t          px_o
);

    logic [HUE_W-1:0] base_c, q_c, hue_c, raw_c;

    always_comb begin
        base_c = hue_base(attr_i.sec, attr_i.neg);
        q_c    = HUE_W'(quot_i);
        raw_c  = attr_i.neg ? (base_c - q_c) : (base_c + q_c);
        if (attr_i.sec == SEC_GRAY || raw_c == HUE_FULL) hue_c = '0;
        else                                             hue_c = raw_c;
    end

    logic v_s;
    out_t px_s;

    always_ff @(posedge clk) begin
        if (rst) v_s <= 1'b0;
        else     v_s <= v_i;
        px_s.mx  <= attr_i.mx;
        px_s.mn  <= attr_i.mn;
        px_s.df  <= attr_i.df;
        px_s.sm  <= attr_i.sm;
        px_s.hue <= hue_c;
    end

    // balancing delay up to the fixed latency
    generate
        if (PAD == 0) begin : g_nopad
            assign v_o  = v_s;
            assign px_o = px_s;
        end else begin : g_pad
            logic [PAD-1:0] vp;
            out_t           pp [PAD];
            always_ff @(posedge clk) begin
                if (rst) vp <= '0;
                else     vp <= {vp[PAD-2+1-1:0], v_s} >> 0;
                pp[0] <= px_s;
                for (int i = 1; i < PAD; i++) pp[i] <= pp[i-1];
            end
            assign v_o  = vp[PAD-1];
            assign px_o = pp[PAD-1];
        end
    endgenerate

endmodule

// File: rtl/rgb2hmmd.sv
`timescale 1ns/1ps
module rgb2hmmd
    import hmmd_pkg::*;
#(
    parameter int LATENCY = 29
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [PIX_W-1:0] in_r,
    input  logic [PIX_W-1:0] in_g,
    input  logic [PIX_W-1:0] in_b,
    output logic             out_valid,
    output logic [PIX_W-1:0] out_max,
    output logic [PIX_W-1:0] out_min,
    output logic [PIX_W-1:0] out_diff,
    output logic [PIX_W-1:0] out_sum,
    output logic [HUE_W-1:0] out_hue
);

    localparam int CORE = 3 + QW + 1;
    localparam int PAD  = (LATENCY > CORE) ? (LATENCY - CORE) : 0;

    logic  dv [QW+1];
    attr_t da [QW+1];
    div_t  dd [QW+1];

    hmmd_front u_front (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .in_r     (in_r),
        .in_g     (in_g),
        .in_b     (in_b),
        .v_o      (dv[0]),
        .attr_o   (da[0]),
        .div_o    (dd[0])
    );

    generate
        for (genvar i = 0; i < QW; i++) begin : g_div
            hmmd_div_step #(.BIT(QW-1-i)) u_step (
                .clk    (clk),
                .rst    (rst),
                .v_i    (dv[i]),
                .attr_i (da[i]),
                .div_i  (dd[i]),
                .v_o    (dv[i+1]),
                .attr_o (da[i+1]),
                .div_o  (dd[i+1])
            );
        end
    endgenerate

    out_t px;

    hmmd_hue_out #(.PAD(PAD)) u_out (
        .clk    (clk),
        .rst    (rst),
        .v_i    (dv[QW]),
        .attr_i (da[QW]),
        .quot_i (dd[QW].quot),
        .v_o    (out_valid),
        .px_o   (px)
    );

    assign out_max  = px.mx;
    assign out_min  = px.mn;
    assign out_diff = px.df;
    assign out_sum  = px.sm;
    assign out_hue  = px.hue;

endmodule

// File: rtl/hmmd_chk.sv
`timescale 1ns/1ps
module hmmd_chk
    import hmmd_pkg::*;
#(
    parameter int LATENCY = 29
) (
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic [PIX_W-1:0] in_r,
    input logic [PIX_W-1:0] in_g,
    input logic [PIX_W-1:0] in_b,
    input logic             out_valid,
    input logic [PIX_W-1:0] out_max,
    input logic [PIX_W-1:0] out_min,
    input logic [PIX_W-1:0] out_diff,
    input logic [PIX_W-1:0] out_sum,
    input logic [HUE_W-1:0] out_hue
);

    // independent delay of the input stream
    logic [LATENCY-1:0] vsr;
    logic [3*PIX_W-1:0] dpix [LATENCY];

    always_ff @(posedge clk) begin
        if (rst) vsr <= '0;
        else     vsr <= {vsr[LATENCY-2:0], in_valid};
        dpix[0] <= {in_r, in_g, in_b};
        for (int i = 1; i < LATENCY; i++) dpix[i] <= dpix[i-1];
    end

    logic [PIX_W-1:0] dr, dg, db;
    assign {dr, dg, db} = dpix[LATENCY-1];

    a_r11_latency: assert property (@(posedge clk) disable iff (rst)
        out_valid == vsr[LATENCY-1]);

    a_r1_max: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_max >= dr && out_max >= dg && out_max >= db &&
                       (out_max == dr || out_max == dg || out_max == db)));

    a_r1_min: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_min <= dr && out_min <= dg && out_min <= db &&
                       (out_min == dr || out_min == dg || out_min == db)));

    a_r2_diff: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_diff == out_max - out_min));

    a_r3_sum_bounds: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_sum >= out_min && out_sum <= out_max));

    a_r4_gray: assert property (@(posedge clk) disable iff (rst)
        (out_valid && dr == dg && dg == db) |-> (out_hue == '0));

    a_r10_range: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_hue < HUE_W'(360)));

    a_r9_red_first: assert property (@(posedge clk) disable iff (rst)
        (out_valid && dr == out_max && out_diff != '0 && dg >= db)
            |-> (out_hue <= HUE_W'(60)));

    a_r12_reset: assert property (@(posedge clk)
        $past(rst) |-> !out_valid);

endmodule

bind rgb2hmmd hmmd_chk #(.LATENCY(LATENCY)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_r      (in_r),
    .in_g      (in_g),
    .in_b      (in_b),
    .out_valid (out_valid),
    .out_max   (out_max),
    .out_min   (out_min),
    .out_diff  (out_diff),
    .out_sum   (out_sum),
    .out_hue   (out_hue)
);

// File: tb/rgb2hmmd_tb.sv
`timescale 1ns/1ps
module rgb2hmmd_tb;

    localparam int LAT = 29;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       in_valid = 1'b0;
    logic [7:0] in_r = '0, in_g = '0, in_b = '0;
    logic       out_valid;
    logic [7:0] out_max, out_min, out_diff, out_sum;
    logic [8:0] out_hue;

    rgb2hmmd #(.LATENCY(LAT)) u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid),
        .in_r(in_r), .in_g(in_g), .in_b(in_b),
        .out_valid(out_valid), .out_max(out_max), .out_min(out_min),
        .out_diff(out_diff), .out_sum(out_sum), .out_hue(out_hue)
    );

    always #10 clk = ~clk;   // 50 MHz

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit done   = 0;

    always @(posedge clk) cyc <= cyc + 1;

    typedef struct {
        int    mx, mn, df, sm, hue, at;
        string req;
    } exp_t;

    exp_t q[$];

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    function automatic exp_t model(input int r, input int g, input int b, input string req);
        exp_t e;
        e.mx = (r >= g && r >= b) ? r : ((g >= b) ? g : b);
        e.mn = (r <= g && r <= b) ? r : ((g <= b) ? g : b);
        e.df = e.mx - e.mn;
        e.sm = (e.mx + e.mn) / 2;
        if (e.df == 0)      e.hue = 0;
        else if (r == e.mx) e.hue = (g >= b) ? (60 * (g - b)) / e.df
                                             : 360 + (60 * (g - b)) / e.df;
        else if (g == e.mx) e.hue = 120 + (60 * (b - r)) / e.df;
        else                e.hue = 240 + (60 * (r - g)) / e.df;
        if (e.hue == 360) e.hue = 0;
        e.req = req;
        e.at  = 0;
        return e;
    endfunction

    // output monitor, samples away from the rising edge
    always @(negedge clk) begin
        if (!rst) begin
            if (out_valid) begin
                if (q.size() == 0) begin
                    chk("R11 unexpected out_valid", 1, 0);
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    chk("R11 latency", cyc, e.at);
                    chk("R1 max", int'(out_max), e.mx);
                    chk("R1 min", int'(out_min), e.mn);
                    chk("R2 diff", int'(out_diff), e.df);
                    chk("R3 sum", int'(out_sum), e.sm);
                    chk({e.req, " hue"}, int'(out_hue), e.hue);
                    checks++;
                    if (out_hue >= 9'd360) begin
                        fails++;
                        $display("FAIL R10: actual %0d expected <360", out_hue);
                    end
                end
            end else if (q.size() > 0 && q[0].at <= cyc) begin
                chk("R11 missing out_valid", 0, 1);
                void'(q.pop_front());
            end
        end
    end

    task automatic send(input int r, input int g, input int b, input bit v, input string req);
        in_r = 8'(r); in_g = 8'(g); in_b = 8'(b); in_valid = v;
        if (v) begin
            exp_t e;
            e = model(r, g, b, req);
            e.at = cyc + LAT;
            q.push_back(e);
        end
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic drain();
        repeat (LAT + 4) @(negedge clk);
        chk("R11 queue empty", q.size(), 0);
    endtask

    // R12: reset state
    task automatic t_reset();
        repeat (4) begin
            @(negedge clk);
            chk("R12 out_valid during reset", int'(out_valid), 0);
        end
        rst = 1'b0;
        repeat (LAT + 3) begin
            @(negedge clk);
            chk("R12 idle after reset", int'(out_valid), 0);
        end
    endtask

    // R4: gray pixels
    task automatic t_gray();
        send(0, 0, 0, 1, "R4");
        send(255, 255, 255, 1, "R4");
        send(77, 77, 77, 1, "R4");
        drain();
    endtask

    // R5 and R3 odd sum
    task automatic t_red_pos();
        send(200, 100, 50, 1, "R5");   // 60*50/150 = 20
        send(201, 0, 0, 1, "R5");      // hue 0, sum 100
        send(250, 249, 0, 1, "R5");    // 59
        drain();
    endtask

    // R6: negative red sector and the 360 wrap
    task automatic t_red_neg();
        send(200, 50, 100, 1, "R6");   // 340
        send(255, 0, 254, 1, "R6");    // 301
        send(255, 100, 101, 1, "R6");  // 360 -> 0
        drain();
    endtask

    // R7: green sector both signs
    task automatic t_green();
        send(50, 200, 100, 1, "R7");   // 140
        send(100, 200, 50, 1, "R7");   // 100
        send(0, 255, 1, 1, "R7");      // 120
        drain();
    endtask

    // R8: blue sector both signs
    task automatic t_blue();
        send(100, 50, 200, 1, "R8");   // 260
        send(50, 100, 200, 1, "R8");   // 220
        send(3, 0, 10, 1, "R8");       // 258
        drain();
    endtask

    // R9: ties for the maximum
    task automatic t_ties();
        send(255, 255, 0, 1, "R9");    // red wins: 60
        send(255, 0, 255, 1, "R9");    // red wins: 300
        send(0, 200, 200, 1, "R9");    // green wins: 180
        drain();
    endtask

    // R11: full throughput stream with gaps, mixing gray and chromatic
    task automatic t_stream();
        for (int k = 0; k < 300; k++) begin
            int r, g, b;
            r = (k * 37 + 11) % 256;
            g = (k * 91 + 5) % 256;
            b = (k * 53) % 256;
            if (k % 7 == 3) begin g = r; b = r; end
            send(r, g, b, (k % 11) != 10, "R11");
        end
        drain();
    endtask

    // R12: reset with pixels in flight
    task automatic t_mid_reset();
        for (int k = 0; k < 8; k++) send(10 * k, 200, 30, 1, "R12");
        rst = 1'b1;
        @(negedge clk);
        q.delete();
        chk("R12 out_valid after reset edge", int'(out_valid), 0);
        @(negedge clk);
        rst = 1'b0;
        repeat (LAT + 3) begin
            @(negedge clk);
            chk("R12 no leak of flushed pixels", int'(out_valid), 0);
        end
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_gray();
        t_red_pos();
        t_red_neg();
        t_green();
        t_blue();
        t_ties();
        t_stream();
        t_mid_reset();
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule